// File: doc/BRIEF.md
# Command-Queued I2C Master Engine

This block runs I2C controller transfers from three small queues instead of byte-by-byte register handshakes. Software queues command words and 32-bit transmit words, then raises a run level. The engine takes one command at a time. A command can open with a start condition, move a byte count in either direction, and close with a stop condition. It can also leave SCL held low when it finishes, or NAK the last byte it receives. Received bytes are packed four to a word into a receive queue. Sticky flags report normal completion, a missing acknowledge, early termination and lost arbitration.

Bus timing is not part of this block. The engine asks a separate timing block for one bus operation at a time: a start condition, a stop condition, writing one bit or reading one bit. It waits for that block to report completion, together with the sampled bit and an arbitration-loss indication.

The sequencer has five states. S_IDLE waits for a command. S_START requests a start condition. S_BIT moves one data bit. S_ACK handles the acknowledge slot. S_STOP requests a stop condition. The transitions are as follows:
- load: S_IDLE goes to S_START, S_BIT or S_STOP, or stays in S_IDLE when a command with no work completes at once.
- byte: S_START goes to S_BIT.
- slot: S_BIT goes to S_ACK after the eighth bit.
- next: S_ACK goes back to S_BIT.
- close: S_START or S_ACK goes to S_STOP.
- finish: S_START, S_ACK or S_STOP goes to S_IDLE.
- abort: any state that has an operation in flight goes to S_IDLE when arbitration is lost.

Top module: `i2cq_master`

## Requirements
- R1: After reset, cmd_ready and tx_ready are 1, tx_empty and rx_empty are 1, flags is 0, and bit_req and scl_hold are 0.
- R2: Queued commands cause no bus operation while run is 0. Once run is 1, commands execute in queue order.
- R3: Command word fields are as follows. Bits 7:0 are the byte count. Bit 8 requests a start condition before the bytes. Bit 9 requests a stop condition after them. Bit 10 is the direction, with 1 meaning transmit. Bit 11 is retain-clock. Bit 12 is NAK-on-last.
- R4: Byte k of a transmit command comes from byte lane k mod 4 of the (k div 4)-th transmit word, taken least significant lane first. Each byte goes out most significant bit first. A final partial word supplies only its low lanes, and every command starts on a fresh word.
- R5: Receive bytes are packed with the earliest byte in the least significant lane. A word is pushed after its fourth byte or after the command's last byte, with unused upper lanes set to zero. The master acknowledges every byte with 0, except that the last byte gets 1 when NAK-on-last is set.
- R6: scl_hold rises when a command with retain-clock completes. It falls when the next command is loaded or on soft reset.
- R7: A 1 read in a transmit acknowledge slot is a missing acknowledge. The engine issues a stop operation, sets flag bit 1 and discards all queued commands and transmit words. It does not set the done flag.
- R8: Early termination happens when run is 0 as a byte's acknowledge slot completes and more bytes remain. The engine delivers any received partial word, issues a stop operation, sets flag bit 2 and discards the queued commands and transmit words.
- R9: If bit_lost is high while an operation other than stop completes, the engine issues no further operation and sets flag bit 3. It issues no stop and flushes the command and transmit queues.
- R10: Flag bit 0 (done) is set each time a command completes normally. Every flag stays set until a 1 is written to the same bit of flag_clr. A new event takes priority over the clear.
- R11: Each queue holds 4 entries. cmd_ready and tx_ready are 0 while their queue is full. rx_rdata shows the oldest receive word, and rx_pop removes it.
- R12: soft_rst returns the engine to S_IDLE, empties all three queues, clears the flags and releases bit_req and scl_hold.
- R13: Operation codes on bit_op are 0 for start, 1 for stop, 2 for write bit and 3 for read bit. While bit_req is 1, bit_op and bit_wr hold steady until a cycle in which bit_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous engine reset |
| run | input | 1 | Lets queued commands execute |
| cmd_valid | input | 1 | Command write strobe |
| cmd_wdata | input | 13 | Command word |
| cmd_ready | output | 1 | Command queue has room |
| tx_valid | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Transmit word |
| tx_ready | output | 1 | Transmit queue has room |
| tx_empty | output | 1 | Transmit queue empty |
| rx_rdata | output | 32 | Oldest receive word |
| rx_pop | input | 1 | Remove oldest receive word |
| rx_empty | output | 1 | Receive queue empty |
| flags | output | 4 | Sticky flags: done, no-ack, early, arbitration |
| flag_clr | input | 4 | Write-1-to-clear for flags |
| bit_req | output | 1 | Bus operation request to timing block |
| bit_op | output | 2 | Requested operation code |
| bit_wr | output | 1 | Bit to drive for a write operation |
| bit_done | input | 1 | Timing block completed the operation |
| bit_rd | input | 1 | Sampled SDA for a read operation |
| bit_lost | input | 1 | Arbitration lost during the operation |
| scl_hold | output | 1 | Keep SCL low between commands |

## Verification
The bench builds the engine with its default values: a queue depth of 4, an 8-bit count and 32-bit data words. With four lanes per word, a six-byte command spans one full word and one partial word, and a single byte pushed after it shows the fresh-word rule. A depth of 4 means four writes with run low are enough to reach transmit backpressure. The bench also plays the timing block and the target. It supplies read bits, acknowledge responses and arbitration loss at chosen bits, and it checks on every clock that a requested operation holds steady until it completes.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
    typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_STOP} seq_state_t;

    localparam logic [1:0] OP_START = 2'd0;
    localparam logic [1:0] OP_STOP  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;
    localparam logic [1:0] OP_READ  = 2'd3;

    localparam int NFLAGS  = 4;
    localparam int F_DONE  = 0;
    localparam int F_NOACK = 1;
    localparam int F_EARLY = 2;
    localparam int F_ARB   = 3;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    // R11: a push into a full queue without a pop leaves it full and bounded
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);
    a_r11_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run,
    input  logic              cmd_nempty,
    input  logic [CNT_W+4:0]  cmd_word,
    output logic              cmd_pop,
    input  logic              tx_nempty,
    input  logic [DW-1:0]     tx_word,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DW-1:0]     rx_word,
    output logic              bit_req,
    output logic [1:0]        bit_op,
    output logic              bit_wr,
    input  logic              bit_done,
    input  logic              bit_rd,
    input  logic              bit_lost,
    output logic              scl_hold,
    output logic              flush,
    output logic [NFLAGS-1:0] set_flags
);
    localparam int LANES  = DW / 8;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int B_START = CNT_W;
    localparam int B_STOP  = CNT_W + 1;
    localparam int B_TX    = CNT_W + 2;
    localparam int B_RET   = CNT_W + 3;
    localparam int B_NAK   = CNT_W + 4;

    seq_state_t        st, st_n;
    logic [CNT_W-1:0]  left;
    logic              c_stop, c_tx, c_ret, c_nak, abt;
    logic [2:0]        bitcnt;
    logic [LANE_W-1:0] lane;
    logic [7:0]        shreg;
    logic [DW-1:0]     rxacc, acc_m;
    logic [7:0]        tx_byte;
    logic [CNT_W-1:0]  cmd_count;
    logic              fire, last, lane_end;

    assign cmd_count = cmd_word[CNT_W-1:0];
    assign fire      = bit_req && bit_done;
    assign last      = (left == CNT_W'(1));
    assign lane_end  = (lane == LANE_W'(LANES - 1));
    assign tx_byte   = tx_word[lane*8 +: 8];

    always_comb begin
        acc_m = rxacc;
        acc_m[lane*8 +: 8] = shreg;
    end
    assign rx_word = acc_m;

    // next state and event pulses
    always_comb begin
        st_n      = st;
        cmd_pop   = 1'b0;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        flush     = 1'b0;
        set_flags = '0;
        unique case (st)
            S_IDLE: if (run && cmd_nempty) begin
                cmd_pop = 1'b1;
                if (cmd_word[B_START])         st_n = S_START;
                else if (cmd_count != '0)      st_n = S_BIT;
                else if (cmd_word[B_STOP])     st_n = S_STOP;
                else                           set_flags[F_DONE] = 1'b1;
            end
            S_START: if (fire) begin
                if (bit_lost) begin
                    set_flags[F_ARB] = 1'b1;
                    flush = 1'b1;
                    st_n  = S_IDLE;
                end else if (left != '0) st_n = S_BIT;
                else if (c_stop)         st_n = S_STOP;
                else begin
                    set_flags[F_DONE] = 1'b1;
                    st_n = S_IDLE;
                end
            end
            S_BIT: if (fire) begin
                if (bit_lost) begin
                    set_flags[F_ARB] = 1'b1;
                    flush = 1'b1;
                    st_n  = S_IDLE;
                end else if (bitcnt == 3'd7) st_n = S_ACK;
            end
            S_ACK: if (fire) begin
                if (bit_lost) begin
                    set_flags[F_ARB] = 1'b1;
                    flush = 1'b1;
                    st_n  = S_IDLE;
                end else if (c_tx && bit_rd) begin
                    set_flags[F_NOACK] = 1'b1;
                    flush = 1'b1;
                    st_n  = S_STOP;
                end else begin
                    if (c_tx && (lane_end || last))           tx_pop  = 1'b1;
                    if (!c_tx && (lane_end || last || !run))  rx_push = 1'b1;
                    if (last) begin
                        if (c_stop) st_n = S_STOP;
                        else begin
                            set_flags[F_DONE] = 1'b1;
                            st_n = S_IDLE;
                        end
                    end else if (!run) begin
                        set_flags[F_EARLY] = 1'b1;
                        flush = 1'b1;
                        st_n  = S_STOP;
                    end else st_n = S_BIT;
                end
            end
            S_STOP: if (fire) begin
                st_n = S_IDLE;
                if (!abt) set_flags[F_DONE] = 1'b1;
            end
            default: st_n = S_IDLE;
        endcase
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE; left <= '0; c_stop <= 1'b0; c_tx <= 1'b0; c_ret <= 1'b0;
            c_nak <= 1'b0; abt <= 1'b0; bitcnt <= '0; lane <= '0; shreg <= '0;
            rxacc <= '0; scl_hold <= 1'b0;
        end else if (soft_rst) begin
            st <= S_IDLE; left <= '0; c_stop <= 1'b0; c_tx <= 1'b0; c_ret <= 1'b0;
            c_nak <= 1'b0; abt <= 1'b0; bitcnt <= '0; lane <= '0; shreg <= '0;
            rxacc <= '0; scl_hold <= 1'b0;
        end else begin
            st <= st_n;
            if (cmd_pop) begin
                left   <= cmd_count;
                c_stop <= cmd_word[B_STOP];
                c_tx   <= cmd_word[B_TX];
                c_ret  <= cmd_word[B_RET];
                c_nak  <= cmd_word[B_NAK];
                bitcnt <= '0;
                lane   <= '0;
                rxacc  <= '0;
                abt    <= 1'b0;
            end
            if (st == S_BIT && fire) begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[6:0], bit_rd};
            end
            if (st == S_ACK && fire) begin
                left  <= left - 1'b1;
                lane  <= last ? '0 : lane + 1'b1;
                rxacc <= rx_push ? '0 : acc_m;
                abt   <= flush;
            end
            if (set_flags[F_DONE])
                scl_hold <= (st == S_IDLE) ? cmd_word[B_RET] : c_ret;
            else if (cmd_pop)
                scl_hold <= 1'b0;
        end
    end

    // outputs toward the timing block
    always_comb begin
        bit_req = 1'b0;
        bit_op  = OP_START;
        bit_wr  = 1'b1;
        unique case (st)
            S_IDLE: ;
            S_START: bit_req = 1'b1;
            S_BIT: begin
                bit_req = !c_tx || tx_nempty;
                bit_op  = c_tx ? OP_WRITE : OP_READ;
                bit_wr  = c_tx ? tx_byte[3'd7 - bitcnt] : 1'b1;
            end
            S_ACK: begin
                bit_req = c_tx || !rx_full;
                bit_op  = c_tx ? OP_READ : OP_WRITE;
                bit_wr  = c_tx ? 1'b1 : (c_nak && last);
            end
            S_STOP: begin
                bit_req = 1'b1;
                bit_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    a_r2_no_op_without_run: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !run && !soft_rst) |=> !bit_req);
    a_r13_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req && !bit_done && !soft_rst) |=>
        (bit_req && bit_op == $past(bit_op) && bit_wr == $past(bit_wr)));
    a_r7_nak_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ACK && fire && c_tx && bit_rd && !bit_lost && !soft_rst) |=> (st == S_STOP));
    a_r9_arb_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && bit_lost && st != S_STOP && !soft_rst) |=> (st == S_IDLE && !bit_req));
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (st == S_IDLE));
    a_r12_soft: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st == S_IDLE && !scl_hold && !bit_req));
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run,
    input  logic              cmd_valid,
    input  logic [CNT_W+4:0]  cmd_wdata,
    output logic              cmd_ready,
    input  logic              tx_valid,
    input  logic [DW-1:0]     tx_wdata,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic [DW-1:0]     rx_rdata,
    input  logic              rx_pop,
    output logic              rx_empty,
    output logic [NFLAGS-1:0] flags,
    input  logic [NFLAGS-1:0] flag_clr,
    output logic              bit_req,
    output logic [1:0]        bit_op,
    output logic              bit_wr,
    input  logic              bit_done,
    input  logic              bit_rd,
    input  logic              bit_lost,
    output logic              scl_hold
);
    localparam int CMD_W = CNT_W + 5;

    logic             cmd_full, cmd_empty, cmd_pop;
    logic [CMD_W-1:0] cmd_word;
    logic             tx_full, tx_pop;
    logic [DW-1:0]    tx_word;
    logic             rx_full, rx_push;
    logic [DW-1:0]    rx_word;
    logic             flush;
    logic [NFLAGS-1:0] set_flags;

    assign cmd_ready = !cmd_full;
    assign tx_ready  = !tx_full;

    i2cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmdq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst || flush),
        .push(cmd_valid), .din(cmd_wdata), .full(cmd_full),
        .pop(cmd_pop), .dout(cmd_word), .empty(cmd_empty));

    i2cq_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst || flush),
        .push(tx_valid), .din(tx_wdata), .full(tx_full),
        .pop(tx_pop), .dout(tx_word), .empty(tx_empty));

    i2cq_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(rx_push), .din(rx_word), .full(rx_full),
        .pop(rx_pop), .dout(rx_rdata), .empty(rx_empty));

    i2cq_seq #(.CNT_W(CNT_W), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
        .cmd_nempty(!cmd_empty), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
        .tx_nempty(!tx_empty), .tx_word(tx_word), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .bit_req(bit_req), .bit_op(bit_op), .bit_wr(bit_wr),
        .bit_done(bit_done), .bit_rd(bit_rd), .bit_lost(bit_lost),
        .scl_hold(scl_hold), .flush(flush), .set_flags(set_flags));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flags <= '0;
        else if (soft_rst) flags <= '0;
        else               flags <= (flags & ~flag_clr) | set_flags;
    end

    // R10: a flag not being cleared stays set
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

// File: tb/i2cq_master_test.sv
module i2cq_master_test;
    localparam logic [12:0] CS = 13'h100, CP = 13'h200, CT = 13'h400, CR = 13'h800, CN = 13'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, soft_rst = 1'b0, run = 1'b0;
    logic        cmd_valid = 1'b0, tx_valid = 1'b0, rx_pop = 1'b0;
    logic [12:0] cmd_wdata = '0;
    logic [31:0] tx_wdata = '0;
    logic [3:0]  flag_clr = '0;
    logic        cmd_ready, tx_ready, tx_empty, rx_empty, bit_req, bit_wr, scl_hold;
    logic [31:0] rx_rdata;
    logic [3:0]  flags;
    logic [1:0]  bit_op;
    logic        bit_done = 1'b0, bit_rd = 1'b1, bit_lost = 1'b0;

    int checks = 0, errors = 0;
    int wlog[$];
    int alog[$];
    int n_start = 0, n_stop = 0, pos = 0, rbyte = 0;
    int nack_byte = -1, lose_cnt = 0, r13_bad = 0;
    logic [7:0] wb = '0;
    logic [7:0] rsrc [8];
    logic       pend = 1'b0;
    logic [1:0] pend_op = '0;
    logic       pend_wr = 1'b0;
    bit         over = 1'b0;

    always #5 clk = ~clk;

    i2cq_master uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
        .cmd_valid(cmd_valid), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .tx_valid(tx_valid), .tx_wdata(tx_wdata), .tx_ready(tx_ready), .tx_empty(tx_empty),
        .rx_rdata(rx_rdata), .rx_pop(rx_pop), .rx_empty(rx_empty),
        .flags(flags), .flag_clr(flag_clr),
        .bit_req(bit_req), .bit_op(bit_op), .bit_wr(bit_wr),
        .bit_done(bit_done), .bit_rd(bit_rd), .bit_lost(bit_lost), .scl_hold(scl_hold));

    // behavioural timing block and target model
    always @(posedge clk) begin
        if (pend && !(bit_req && bit_op == pend_op && bit_wr == pend_wr)) r13_bad++;
        pend    <= bit_req && !bit_done;
        pend_op <= bit_op;
        pend_wr <= bit_wr;
        if (!rst_n) begin
            bit_done <= 1'b0;
        end else if (bit_req && bit_done) begin
            case (bit_op)
                2'd0: begin n_start++; pos = 0; end
                2'd1: begin n_stop++;  pos = 0; end
                2'd2: if (pos < 8) begin
                          wb = {wb[6:0], bit_wr}; pos++;
                          if (pos == 8) wlog.push_back(int'(wb));
                      end else begin alog.push_back(int'(bit_wr)); pos = 0; end
                default: if (pos < 8) begin pos++; if (pos == 8) rbyte++; end
                         else pos = 0;
            endcase
            bit_done <= 1'b0;
            bit_lost <= 1'b0;
        end else if (bit_req) begin
            bit_done <= 1'b1;
            bit_lost <= 1'b0;
            bit_rd   <= 1'b1;
            if (bit_op == 2'd3) begin
                if (pos < 8) bit_rd <= rsrc[rbyte % 8][7 - pos];
                else         bit_rd <= ((wlog.size() - 1) == nack_byte);
            end
            if (bit_op == 2'd2 && lose_cnt > 0) begin
                lose_cnt--;
                if (lose_cnt == 0) bit_lost <= 1'b1;
            end
        end else begin
            bit_done <= 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [12:0] w);
        @(negedge clk); cmd_valid = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic push_tx(input logic [31:0] w);
        @(negedge clk); tx_valid = 1'b1; tx_wdata = w;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic pop_rx(output logic [31:0] w);
        @(negedge clk); w = rx_rdata; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic wait_flag(input int b);
        while (flags[b] !== 1'b1) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); flag_clr = 4'hF;
        @(negedge clk); flag_clr = 4'h0;
        wlog.delete(); alog.delete();
        n_start = 0; n_stop = 0; rbyte = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        for (int i = 0; i < 8; i++) rsrc[i] = 8'(8'h11 * (i + 1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 tx_ready", int'(tx_ready), 1);
        chk("R1 queues empty", int'({tx_empty, rx_empty}), 3);
        chk("R1 flags", int'(flags), 0);
        chk("R1 bus idle", int'({bit_req, scl_hold}), 0);

        // R3 R4 basic write, held back until run
        push_cmd(CS | CP | CT | 13'd4);
        push_tx(32'h563412A0);
        repeat (10) @(negedge clk);
        chk("R2 no op while run low", n_start + int'(bit_req), 0);
        run = 1'b1;
        wait_flag(0);
        chk("R4 byte count", wlog.size(), 4);
        chk("R4 byte0", wlog[0], 'hA0);
        chk("R4 byte1", wlog[1], 'h12);
        chk("R4 byte3", wlog[3], 'h56);
        chk("R3 start/stop", n_start * 16 + n_stop, 'h11);
        chk("R10 done flag", int'(flags), 1);
        chk("R11 tx empty", int'(tx_empty), 1);
        @(negedge clk); flag_clr = 4'b0001;
        @(negedge clk); flag_clr = 4'b0000;
        chk("R10 flag cleared", int'(flags), 0);
        clear_all();

        // R4 partial word and fresh word per command
        push_cmd(CS | CP | CT | 13'd6);
        push_cmd(CS | CP | CT | 13'd1);
        push_tx(32'h44332211);
        push_tx(32'hAAAA6655);
        push_tx(32'h000000A4);
        while (n_stop < 2) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R4 total bytes", wlog.size(), 7);
        chk("R4 lane order", wlog[3], 'h44);
        chk("R4 partial low lanes", wlog[5], 'h66);
        chk("R4 fresh word", wlog[6], 'hA4);
        chk("R2 in order starts", n_start, 2);
        clear_all();

        // R5 R6 register read sequence
        push_cmd(CS | CT | 13'd2);
        push_cmd(CS | CT | CR | 13'd1);
        push_cmd(CP | CN | 13'd5);
        push_tx(32'h000005A0);
        push_tx(32'h000000A1);
        while (n_stop < 1) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R5 addr bytes", wlog.size() * 256 + wlog[2], 'h3A1);
        chk("R5 master acks", alog.size(), 5);
        chk("R5 ack on early byte", alog[3], 0);
        chk("R5 nak on last", alog[4], 1);
        pop_rx(w);
        chk("R5 first word", int'(w), 'h44332211);
        pop_rx(w);
        chk("R5 partial word", int'(w), 'h00000055);
        chk("R11 rx empty after pops", int'(rx_empty), 1);
        chk("R6 hold released by next command", int'(scl_hold), 0);
        clear_all();

        // R6 retain clock
        push_cmd(CS | CT | CR | 13'd1);
        push_tx(32'h000000A0);
        wait_flag(0);
        chk("R6 hold after retain", int'(scl_hold), 1);
        chk("R6 no stop", n_stop, 0);
        clear_all();
        push_cmd(CP);
        wait_flag(0);
        chk("R6 hold dropped", int'(scl_hold), 0);
        chk("R3 stop-only command", n_stop, 1);
        clear_all();

        // R7 missing acknowledge
        nack_byte = 0;
        push_cmd(CS | CP | CT | 13'd2);
        push_cmd(CS | CP | CT | 13'd1);
        push_tx(32'h000012A0);
        push_tx(32'h000000A2);
        wait_flag(1);
        repeat (20) @(negedge clk);
        chk("R7 one byte sent", wlog.size(), 1);
        chk("R7 stop issued", n_stop, 1);
        chk("R7 queue flushed", n_start, 1);
        chk("R7 flags", int'(flags), 'b0010);
        chk("R7 tx flushed", int'({tx_empty, cmd_ready}), 3);
        nack_byte = -1;
        clear_all();

        // R8 early termination
        push_cmd(CS | CP | CN | 13'd6);
        while (alog.size() < 2) @(negedge clk);
        run = 1'b0;
        wait_flag(2);
        chk("R8 bytes read", alog.size(), 3);
        chk("R8 stop", n_stop, 1);
        chk("R8 flags", int'(flags), 'b0100);
        pop_rx(w);
        chk("R8 partial delivered", int'(w), 'h00332211);
        run = 1'b1;
        clear_all();

        // R9 arbitration loss
        lose_cnt = 3;
        push_cmd(CS | CP | CT | 13'd2);
        push_tx(32'h000012A0);
        wait_flag(3);
        repeat (10) @(negedge clk);
        chk("R9 no stop", n_stop, 0);
        chk("R9 released", int'(bit_req), 0);
        chk("R9 flags", int'(flags), 'b1000);
        chk("R9 tx flushed", int'(tx_empty), 1);

        // R11 backpressure, R12 soft reset
        run = 1'b0;
        for (int i = 0; i < 4; i++) push_tx(32'h0 + i);
        chk("R11 tx full", int'(tx_ready), 0);
        push_cmd(CS | CT | 13'd1);
        push_cmd(CS | CT | 13'd1);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R12 queues emptied", int'({tx_ready, tx_empty, cmd_ready}), 7);
        chk("R12 flags cleared", int'(flags), 0);
        n_start = 0;
        run = 1'b1;
        repeat (20) @(negedge clk);
        chk("R12 no leftover command", n_start, 0);
        chk("R13 op held until done", r13_bad, 0);

        if (!over) begin
            over = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule